// File: doc/BRIEF.md
# Block-Transfer Host Register Window

This block is the host-facing side of a block-transfer management mailbox. A host reaches it through a byte-wide register window of three registers: control, data and interrupt mask. The host writes a request into a request buffer one byte at a time. It then rings a doorbell bit, which marks the engine busy and sends a one-cycle strobe to the message engine. The engine reads the request back through its own read port. It places a response into a response buffer and commits that response with a load strobe. The host then drains the response one byte at a time through the data register.

Several control bits act as commands rather than stored values. They clear a flag, toggle a flag, rewind a pointer or start a request. The interrupt mask register holds an enable and a pending flag. The pending flag is raised and lowered by response loads, by changes to the event-attention level that the engine requests, and by host writes. The level interrupt is the registered AND of the pending flag and a global allow input. The engine-side buffers are simple dual-port byte memories so that they map onto block RAM.

Top module: `bthr_host_if`

## Requirements
- R1: The register offset is `bus_addr & (WIN-1)`. Offset 0 is control, offset 1 is data and offset 2 is mask. A read of any other offset returns 0xFF, and a write to one changes nothing. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd` and holds until the next read.
- R2: A control read returns engine busy in bit 7, host busy in bit 6, event attention in bit 4 and response attention in bit 3, with every other bit 0. A mask read returns pending in bit 1 and enable in bit 0, with every other bit 0. Both registers read 0 after reset.
- R3: A control write with bit 3 set clears response attention. Bit 4 set clears event attention. Bit 6 set toggles host busy. Zero bits have no effect.
- R4: A control write with bit 2 set sets engine busy. It also drives `req_ready` high for exactly the one cycle after that write's edge.
- R5: A data write stores its byte at the current count only while the count is below DEPTH. The count rises on every data write and saturates at 2^(log2(DEPTH)+2)-1. `req_len` shows the count. A control write with bit 0 set returns the count to 0. `eng_rdata` shows the byte at `eng_raddr` one cycle later.
- R6: A data read returns the response byte at the read pointer and advances the pointer. Reading the last byte returns both the pointer and the response length to 0. A read with nothing pending returns 0xFF. A control write with bit 1 set rewinds the pointer to 0.
- R7: A mask write that turns bit 0 (enable) from 0 to 1 sets pending when response attention or event attention is set.
- R8: A mask write that turns enable from 1 to 0 clears pending. A mask write with bit 1 set clears pending. Pending is never set while enable is 0.
- R9: `rsp_load` takes `rsp_len` as the response length, clamped to DEPTH, and rewinds the read pointer. It clears engine busy and sets response attention. It sets pending when enable is set.
- R10: An `evt_req` whose `evt_val` differs from event attention copies the value into event attention. A rise sets pending when response attention is clear and enable is set. A fall clears pending when response attention is clear. An `evt_req` equal to the current level changes nothing.
- R11: `irq` is the registered AND of the next pending value and `irq_allow`. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid after the read edge |
| irq_allow | input | 1 | Global interrupt allow |
| irq | output | 1 | Level interrupt to the host |
| req_ready | output | 1 | One-cycle strobe: request complete |
| req_len | output | log2(DEPTH)+2 | Request byte count, including overrun |
| eng_raddr | input | log2(DEPTH) | Engine read address into the request buffer |
| eng_rdata | output | 8 | Request byte at eng_raddr, one cycle later |
| rsp_we | input | 1 | Engine write into the response buffer |
| rsp_waddr | input | log2(DEPTH) | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |
| rsp_load | input | 1 | Commit a response of rsp_len bytes |
| rsp_len | input | log2(DEPTH)+1 | Length of the committed response |
| evt_req | input | 1 | Request to change event attention |
| evt_val | input | 1 | Requested event attention level |

## Verification
The hardest state to reach is one where pending depends on both attention sources at once. An example is event attention falling while response attention is still set, so that pending must survive. Another is enabling interrupts when only the event flag is set. Reaching these takes a chosen order of response loads, event requests and control-bit clears. Directed steps build them explicitly. A long random run then mixes host writes with random bit patterns, response loads and event requests, so that the combinations arise in many orders. A bench model predicts every register read and the interrupt level after each step.

// File: rtl/bthr_pkg.sv
package bthr_pkg;
  // register offsets inside the window
  localparam int OFS_CTRL = 0;
  localparam int OFS_DATA = 1;
  localparam int OFS_MASK = 2;

  // control bit positions
  localparam int CB_CLR_WR    = 0;
  localparam int CB_CLR_RD    = 1;
  localparam int CB_REQ_DONE  = 2;
  localparam int CB_RSP_ATN   = 3;
  localparam int CB_EVT_ATN   = 4;
  localparam int CB_HOST_BUSY = 6;
  localparam int CB_ENG_BUSY  = 7;

  // mask bit positions
  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  typedef struct packed {
    logic eng_busy;
    logic host_busy;
    logic evt_atn;
    logic rsp_atn;
  } flags_t;

  typedef struct packed {
    logic pend;
    logic en;
  } mask_t;
endpackage

// File: rtl/bthr_req_buf.sv
module bthr_req_buf #(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [7:0]                   wdata,
  input  logic                         clr,
  output logic [$clog2(DEPTH)+1:0]     count,
  input  logic [$clog2(DEPTH)-1:0]     eng_raddr,
  output logic [7:0]                   eng_rdata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0] mem [DEPTH];
  logic       room;

  assign room = (count < CNT_W'(DEPTH));

  // byte store: only while there is room
  always_ff @(posedge clk) begin
    if (wr_en && room) begin
      mem[count[PTR_W-1:0]] <= wdata;
    end
    eng_rdata <= mem[eng_raddr];
  end

  // write count keeps rising past the end so an overrun is visible
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (wr_en && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bthr_rsp_buf.sv
module bthr_rsp_buf #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       eng_we,
  input  logic [$clog2(DEPTH)-1:0]   eng_waddr,
  input  logic [7:0]                 eng_wdata,
  input  logic                       load,
  input  logic [$clog2(DEPTH):0]     load_len,
  input  logic                       host_rd,
  input  logic                       ptr_clr,
  output logic [7:0]                 host_q
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = PTR_W + 1;

  logic [7:0]       mem [DEPTH];
  logic [7:0]       mem_q;
  logic             hit_q;
  logic [LEN_W-1:0] pos_q, pos_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             avail;

  assign avail = (pos_q < len_q);

  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem[eng_waddr] <= eng_wdata;
    end
    if (host_rd) begin
      mem_q <= mem[pos_q[PTR_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else if (host_rd) begin
      hit_q <= avail;
    end
  end

  assign host_q = hit_q ? mem_q : 8'hFF;

  always_comb begin
    pos_n = pos_q;
    len_n = len_q;
    if (ptr_clr) begin
      pos_n = '0;
    end
    if (host_rd && avail) begin
      if ((pos_q + 1'b1) == len_q) begin
        pos_n = '0;
        len_n = '0;
      end else begin
        pos_n = pos_q + 1'b1;
      end
    end
    if (load) begin
      pos_n = '0;
      len_n = (load_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : load_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      len_q <= '0;
    end else begin
      pos_q <= pos_n;
      len_q <= len_n;
    end
  end
endmodule

// File: rtl/bthr_flags.sv
module bthr_flags
  import bthr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic        mask_we,
  input  logic [7:0]  wdata,
  input  logic        rsp_load,
  input  logic        evt_req,
  input  logic        evt_val,
  input  logic        irq_allow,
  output flags_t      flg_q,
  output mask_t       msk_q,
  output logic        req_done,
  output logic        irq
);
  flags_t f_n;
  mask_t  m_n;
  logic   done_n;

  // events applied in a fixed order: host write, response load, event request
  always_comb begin
    f_n    = flg_q;
    m_n    = msk_q;
    done_n = 1'b0;

    if (ctrl_we) begin
      if (wdata[CB_RSP_ATN])   f_n.rsp_atn   = 1'b0;
      if (wdata[CB_EVT_ATN])   f_n.evt_atn   = 1'b0;
      if (wdata[CB_HOST_BUSY]) f_n.host_busy = ~flg_q.host_busy;
      if (wdata[CB_REQ_DONE]) begin
        f_n.eng_busy = 1'b1;
        done_n       = 1'b1;
      end
    end

    if (mask_we) begin
      if (wdata[MB_EN] != m_n.en) begin
        if (wdata[MB_EN]) begin
          if (f_n.rsp_atn || f_n.evt_atn) m_n.pend = 1'b1;
          m_n.en = 1'b1;
        end else begin
          m_n.pend = 1'b0;
          m_n.en   = 1'b0;
        end
      end
      if (wdata[MB_PEND] && m_n.pend) m_n.pend = 1'b0;
    end

    if (rsp_load) begin
      f_n.eng_busy = 1'b0;
      f_n.rsp_atn  = 1'b1;
      if (!m_n.pend && m_n.en) m_n.pend = 1'b1;
    end

    if (evt_req && (evt_val != f_n.evt_atn)) begin
      f_n.evt_atn = evt_val;
      if (evt_val) begin
        if (!f_n.rsp_atn && m_n.en) m_n.pend = 1'b1;
      end else begin
        if (!f_n.rsp_atn && m_n.pend) m_n.pend = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q    <= '0;
      msk_q    <= '0;
      req_done <= 1'b0;
      irq      <= 1'b0;
    end else begin
      flg_q    <= f_n;
      msk_q    <= m_n;
      req_done <= done_n;
      irq      <= m_n.pend && irq_allow;
    end
  end
endmodule

// File: rtl/bthr_host_if.sv
module bthr_host_if
  import bthr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN    = 4,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic                       irq_allow,
  output logic                       irq,
  output logic                       req_ready,
  output logic [$clog2(DEPTH)+1:0]   req_len,
  input  logic [$clog2(DEPTH)-1:0]   eng_raddr,
  output logic [7:0]                 eng_rdata,
  input  logic                       rsp_we,
  input  logic [$clog2(DEPTH)-1:0]   rsp_waddr,
  input  logic [7:0]                 rsp_wdata,
  input  logic                       rsp_load,
  input  logic [$clog2(DEPTH):0]     rsp_len,
  input  logic                       evt_req,
  input  logic                       evt_val
);
  localparam logic [ADDR_W-1:0] OFS_MSK = ADDR_W'(WIN - 1);

  logic [ADDR_W-1:0] ofs;
  logic              hit_ctrl, hit_data, hit_mask;
  flags_t            flg;
  mask_t             msk;
  logic [7:0]        ctrl_rd, mask_rd, rsp_byte;
  logic [7:0]        reg_q;
  logic              sel_data_q;

  assign ofs      = bus_addr & OFS_MSK;
  assign hit_ctrl = (ofs == ADDR_W'(OFS_CTRL));
  assign hit_data = (ofs == ADDR_W'(OFS_DATA));
  assign hit_mask = (ofs == ADDR_W'(OFS_MASK));

  bthr_req_buf #(.DEPTH(DEPTH)) req_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && hit_data),
    .wdata     (bus_wdata),
    .clr       (bus_wr && hit_ctrl && bus_wdata[CB_CLR_WR]),
    .count     (req_len),
    .eng_raddr (eng_raddr),
    .eng_rdata (eng_rdata)
  );

  bthr_rsp_buf #(.DEPTH(DEPTH)) rsp_i (
    .clk       (clk),
    .rst       (rst),
    .eng_we    (rsp_we),
    .eng_waddr (rsp_waddr),
    .eng_wdata (rsp_wdata),
    .load      (rsp_load),
    .load_len  (rsp_len),
    .host_rd   (bus_rd && hit_data),
    .ptr_clr   (bus_wr && hit_ctrl && bus_wdata[CB_CLR_RD]),
    .host_q    (rsp_byte)
  );

  bthr_flags flags_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (bus_wr && hit_ctrl),
    .mask_we   (bus_wr && hit_mask),
    .wdata     (bus_wdata),
    .rsp_load  (rsp_load),
    .evt_req   (evt_req),
    .evt_val   (evt_val),
    .irq_allow (irq_allow),
    .flg_q     (flg),
    .msk_q     (msk),
    .req_done  (req_ready),
    .irq       (irq)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_ENG_BUSY]  = flg.eng_busy;
    ctrl_rd[CB_HOST_BUSY] = flg.host_busy;
    ctrl_rd[CB_EVT_ATN]   = flg.evt_atn;
    ctrl_rd[CB_RSP_ATN]   = flg.rsp_atn;
    mask_rd = '0;
    mask_rd[MB_PEND] = msk.pend;
    mask_rd[MB_EN]   = msk.en;
  end

  // registered read path; the data byte comes from the buffer's own register
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      sel_data_q <= 1'b0;
    end else if (bus_rd) begin
      sel_data_q <= hit_data;
      if (hit_ctrl)      reg_q <= ctrl_rd;
      else if (hit_mask) reg_q <= mask_rd;
      else               reg_q <= 8'hFF;
    end
  end

  assign bus_rdata = sel_data_q ? rsp_byte : reg_q;
endmodule

// File: rtl/bthr_host_if_chk.sv
module bthr_host_if_chk
  import bthr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              req_ready,
  input logic              rsp_load,
  input logic              evt_req,
  input logic              evt_val,
  input flags_t            flg,
  input mask_t             msk
);
  logic [ADDR_W-1:0] c_ofs;
  logic              c_unmapped;
  assign c_ofs      = bus_addr & ADDR_W'(WIN - 1);
  assign c_unmapped = (c_ofs > ADDR_W'(OFS_MASK));

  assert_unmapped_ff_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_unmapped) |=> (bus_rdata == 8'hFF));

  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && c_ofs == ADDR_W'(OFS_CTRL) && bus_wdata[CB_REQ_DONE] && !rsp_load)
      |=> (req_ready && flg.eng_busy));

  assert_pend_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    msk.pend |-> msk.en);

  assert_load_sets_atn_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_load |=> (flg.rsp_atn && !flg.eng_busy));

  assert_evt_same_level_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_req && (evt_val == flg.evt_atn) && !bus_wr && !rsp_load) |=> $stable(msk));

  assert_irq_from_pend_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> msk.pend);
endmodule

bind bthr_host_if bthr_host_if_chk #(.ADDR_W(ADDR_W), .WIN(WIN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .req_ready (req_ready),
  .rsp_load  (rsp_load),
  .evt_req   (evt_req),
  .evt_val   (evt_val),
  .flg       (flg),
  .msk       (msk)
);

// File: tb/bthr_host_if_tb.sv
module bthr_host_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 8;
  localparam int PTR_W  = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic [ADDR_W-1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_allow = 0, irq, req_ready;
  logic [PTR_W+1:0] req_len;
  logic [PTR_W-1:0] eng_raddr = 0;
  logic [7:0] eng_rdata;
  logic rsp_we = 0;
  logic [PTR_W-1:0] rsp_waddr = 0;
  logic [7:0] rsp_wdata = 0;
  logic rsp_load = 0;
  logic [PTR_W:0] rsp_len = 0;
  logic evt_req = 0, evt_val = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bthr_host_if #(.ADDR_W(ADDR_W), .WIN(4), .DEPTH(DEPTH)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit m_b2h, m_evt, m_hb, m_eb, m_en, m_pend;
  int m_inlen, m_outlen, m_outpos;
  logic [7:0] m_req [DEPTH];
  logic [7:0] m_rsp [DEPTH];

  function automatic logic [7:0] exp_ctrl();
    return {m_eb, m_hb, 1'b0, m_evt, m_b2h, 3'b000};
  endfunction
  function automatic logic [7:0] exp_mask();
    return {6'b0, m_pend, m_en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_irq(string tag);
    check(tag, {31'b0, irq}, {31'b0, m_pend & irq_allow});
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1; bus_wr = 0;
    case (a[1:0])
      2'd0: begin
        if (d[0]) m_inlen = 0;
        if (d[1]) m_outpos = 0;
        if (d[3]) m_b2h = 0;
        if (d[4]) m_evt = 0;
        if (d[6]) m_hb = !m_hb;
        if (d[2]) m_eb = 1;
        check("R4 req_ready pulse", {31'b0, req_ready}, {31'b0, d[2]});
      end
      2'd1: begin
        if (m_inlen < DEPTH) m_req[m_inlen] = d;
        if (m_inlen < 255) m_inlen++;
      end
      2'd2: begin
        if (d[0] != m_en) begin
          if (d[0]) begin if (m_b2h || m_evt) m_pend = 1; m_en = 1; end
          else begin m_pend = 0; m_en = 0; end
        end
        if (d[1] && m_pend) m_pend = 0;
      end
      default: ;
    endcase
    check_irq("R11 irq after write");
  endtask

  task automatic bus_read(logic [7:0] a, string tag);
    logic [7:0] e;
    case (a[1:0])
      2'd0: e = exp_ctrl();
      2'd2: e = exp_mask();
      2'd1: begin
        if (m_outpos < m_outlen) begin
          e = m_rsp[m_outpos]; m_outpos++;
          if (m_outpos == m_outlen) begin m_outpos = 0; m_outlen = 0; end
        end else e = 8'hFF;
      end
      default: e = 8'hFF;
    endcase
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(posedge clk); #1; bus_rd = 0;
    check(tag, {24'b0, bus_rdata}, {24'b0, e});
  endtask

  task automatic load_rsp(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rsp_we = 1; rsp_waddr = PTR_W'(i); rsp_wdata = 8'($urandom);
      m_rsp[i] = rsp_wdata;
    end
    @(negedge clk); rsp_we = 0; rsp_load = 1; rsp_len = (PTR_W+1)'(n);
    @(posedge clk); #1; rsp_load = 0;
    m_outlen = n; m_outpos = 0; m_eb = 0; m_b2h = 1;
    if (!m_pend && m_en) m_pend = 1;
    check_irq("R9 irq after load");
  endtask

  task automatic evt(bit v);
    @(negedge clk); evt_req = 1; evt_val = v;
    @(posedge clk); #1; evt_req = 0;
    if (v != m_evt) begin
      m_evt = v;
      if (v) begin if (!m_b2h && m_en) m_pend = 1; end
      else if (!m_b2h && m_pend) m_pend = 0;
    end
    check_irq("R10 irq after event");
  endtask

  task automatic eng_check(int idx);
    @(negedge clk); eng_raddr = PTR_W'(idx);
    @(posedge clk); #1;
    check("R5 engine request byte", {24'b0, eng_rdata}, {24'b0, m_req[idx]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // reset state
    bus_read(8'h00, "R2 control after reset");
    bus_read(8'h02, "R2 mask after reset");
    bus_read(8'h01, "R6 empty data read");
    check("R5 req_len after reset", 32'(req_len), 0);
    check("R11 irq after reset", {31'b0, irq}, 0);

    // request bytes, doorbell, clear
    for (int i = 0; i < 5; i++) bus_write(8'h01, 8'(8'hA0 + i));
    check("R5 req_len count", 32'(req_len), 5);
    for (int i = 0; i < 5; i++) eng_check(i);
    bus_write(8'h00, 8'h04);
    bus_read(8'h00, "R4 engine busy read");
    bus_write(8'h00, 8'h01);
    check("R5 clear write pointer", 32'(req_len), 0);

    // overrun
    for (int i = 0; i < DEPTH + 6; i++) bus_write(8'h01, 8'(i * 3));
    check("R5 overrun count", 32'(req_len), DEPTH + 6);
    eng_check(DEPTH - 1);
    eng_check(0);
    bus_write(8'h00, 8'h01);

    // response path with interrupts
    irq_allow = 1;
    bus_write(8'h42, 8'h01);             // aliased mask address
    bus_read(8'h02, "R1 aliased mask write");
    load_rsp(4);
    bus_read(8'h00, "R9 attention after load");
    bus_read(8'h02, "R9 pending after load");
    for (int i = 0; i < 5; i++) bus_read(8'h01, "R6 drain response");
    load_rsp(3);
    bus_read(8'h01, "R6 first byte");
    bus_write(8'h00, 8'h02);
    bus_read(8'h01, "R6 rewind re-read");

    // pending clear and enable
    bus_write(8'h02, 8'h03);
    bus_read(8'h02, "R8 write-one clears pending");
    bus_write(8'h02, 8'h00);
    bus_write(8'h02, 8'h01);
    bus_read(8'h02, "R7 enable with attention set");
    bus_write(8'h02, 8'h00);
    bus_read(8'h02, "R8 disable clears pending");

    // event attention
    bus_write(8'h00, 8'h08);
    bus_read(8'h00, "R3 response attention cleared");
    bus_write(8'h02, 8'h01);
    bus_read(8'h02, "R7 enable with no attention");
    evt(1);
    bus_read(8'h02, "R10 rise raises pending");
    evt(1);
    bus_read(8'h02, "R10 same level no change");
    evt(0);
    bus_read(8'h02, "R10 fall lowers pending");
    load_rsp(2);
    evt(1);
    evt(0);
    bus_read(8'h02, "R10 fall with response attention keeps pending");
    bus_write(8'h00, 8'h40);
    bus_write(8'h00, 8'h50);
    bus_read(8'h00, "R3 host busy toggle and event clear");
    irq_allow = 0;
    @(posedge clk); #1;
    check_irq("R11 allow low masks irq");
    bus_read(8'h03, "R1 unmapped read");
    bus_write(8'h07, 8'hFF);
    bus_read(8'h00, "R1 unmapped write ignored ctrl");
    bus_read(8'h02, "R1 unmapped write ignored mask");

    // constrained random mix
    for (int k = 0; k < 1500; k++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a = {6'($urandom), 2'b00};
      case (op)
        0: bus_write(a | 8'd0, 8'($urandom) & 8'hDF);
        1, 2: bus_write(a | 8'd1, 8'($urandom));
        3: bus_write(a | 8'd2, 8'($urandom_range(0, 3)));
        4: bus_read(a | 8'($urandom_range(0, 3)), "R2 random register read");
        5, 6: bus_read(a | 8'd1, "R6 random data read");
        7: load_rsp($urandom_range(1, 8));
        8: evt(1'($urandom));
        default: begin
          irq_allow = 1'($urandom);
          @(posedge clk); #1;
          check_irq("R11 random allow");
        end
      endcase
    end
    check("R5 random req_len", 32'(req_len), 32'(m_inlen));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule